// File: doc/BRIEF.md
# Four-Mode Compare Timer

This block is a 16-bit event counter. It advances only on cycles where a chosen count-enable input is high. Two such enables arrive from outside: a slow auxiliary tick and a faster sub-system tick. A register field selects which one drives the counter. Four run modes decide how the count moves: halted, ramping up to a period limit, free-running through the full range, and bouncing up to the limit and back down to zero.

Three compare channels watch the count. Each one latches a sticky match flag when a tick moves the counter onto that channel's value. Channel 0 does a second job: in the ramp and bounce modes it also sets the period limit. A separate sticky wrap flag marks each return of the count to zero.

Software drives all of this through a one-cycle write port. Through that port it sets the mode and the tick select, zeroes the count, loads compare values and clears flags. A compare value may be rewritten while the counter runs. Stepping a channel forward by a fixed offset after each match therefore gives evenly spaced matches.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, all flags are 0, the mode is halted, the tick select is the auxiliary tick and every compare value is 0.
- R2: The write port decodes by address. Address 0 is the control word: bits [1:0] give the mode (0 halt, 1 ramp, 2 free-run, 3 bounce), bit 2 selects the tick (0 auxiliary, 1 sub-system) and bit 3 is a zeroing strobe. Addresses 1, 2 and 3 load the compare values of channels 0, 1 and 2. Address 4 clears flags: bits 0 to 2 clear the channel flags and bit 3 clears the wrap flag.
- R3: The count moves only on cycles where the selected tick is high. The unselected tick has no effect.
- R4: In halt mode the count keeps its value whatever the ticks do.
- R5: In ramp mode each tick adds 1 until the count equals the channel-0 value C0. The next tick returns it to 0 and sets the wrap flag, so C0 = N-1 gives a period of N ticks. A count already above C0 also returns to 0 on the next tick.
- R6: In free-run mode each tick adds 1 through all 65536 values. The step from 0xFFFF to 0 sets the wrap flag.
- R7: In bounce mode the count climbs to C0, then falls to 0, then climbs again, giving a period of 2*C0 ticks. The wrap flag is set when the count falls to 0. With C0 = 0 the count holds.
- R8: A channel flag is set when a tick moves the count onto that channel's compare value. A count that merely rests on the value while no tick moves it sets nothing.
- R9: Flags stay set until a clear write names them. A clear write and a new match on the same cycle leave the flag set, and clear bits written as 0 leave flags unchanged.
- R10: A control write with the zeroing bit set forces the count to 0 even on a tick cycle and restarts bounce mode climbing. It leaves the flags as they were, and the mode written in the same word takes effect.
- R11: A rewritten compare value takes effect from the next tick. Adding a fixed offset to a channel after each of its matches in free-run mode produces a match every offset ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auxTick | input | 1 | Auxiliary count enable |
| subTick | input | 1 | Sub-system count enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| cmpFlag | output | 3 | Sticky match flags, one per channel |
| wrapFlag | output | 1 | Sticky wrap-to-zero flag |

## Verification
Free-run mode is swept through the full 16-bit range and beyond. This separates a true 0xFFFF-to-0 wrap from an early or missing one, and shows whether compare values at both range ends match. Ramp and bounce are run for several periods with small limits, and each count is checked against the closed forms k mod N and the triangle wave. This separates off-by-one errors at the turning points. Tick patterns that alternate between the two enables separate correct select gating from crossed enables. Collisions of a match with a clear, of the zeroing strobe with a tick, and of a compare rewrite with a moving count separate correct priorities from swapped ones.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    MODE_HALT   = 2'd0,
    MODE_RAMP   = 2'd1,
    MODE_FREE   = 2'd2,
    MODE_BOUNCE = 2'd3
  } modeT;

  // strobes from control to datapath, one move per cycle at most
  typedef struct packed {
    logic inc;      // count + 1
    logic dec;      // count - 1
    logic zero;     // count <= 0
    logic step;     // move caused by a tick (compare may fire)
    logic wrapSet;  // set the wrap flag
  } stepT;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          auxTick,
  input  logic                          subTick,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [CNT_W-1:0]              count,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmpVals,
  output logic [NUM_CH:0]               flagClr,
  output stepT                          stp
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(NUM_CH + 1);
  localparam int SEL_BIT = 2;
  localparam int ZERO_BIT = 3;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  modeT                         modeQ;
  logic                         selQ;
  logic                         dirUpQ;
  logic                         dirNext;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpQ;
  logic                         ctrlWr;
  logic                         clearReq;
  logic                         tick;

  assign ctrlWr   = wrEn && (wrAddr == CTRL_ADDR);
  assign clearReq = ctrlWr && wrData[ZERO_BIT];
  assign tick     = selQ ? subTick : auxTick;
  assign flagClr  = (wrEn && (wrAddr == CLR_ADDR)) ? wrData[NUM_CH:0] : '0;
  assign cmpVals  = cmpQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= MODE_HALT;
      selQ   <= 1'b0;
      dirUpQ <= 1'b1;
    end else begin
      if (ctrlWr) begin
        modeQ <= modeT'(wrData[1:0]);
        selQ  <= wrData[SEL_BIT];
      end
      dirUpQ <= dirNext;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmpReg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmpQ[ch] <= '0;
      end else if (wrEn && (wrAddr == ADDR_W'(ch + 1))) begin
        cmpQ[ch] <= wrData;
      end
    end
  end

  always_comb begin
    stp     = '0;
    dirNext = (modeQ == MODE_BOUNCE) ? dirUpQ : 1'b1;
    if (clearReq) begin
      stp.zero = 1'b1;
      dirNext  = 1'b1;
    end else if (tick) begin
      case (modeQ)
        MODE_RAMP: begin
          stp.step = 1'b1;
          if (count >= cmpQ[0]) begin
            stp.zero    = 1'b1;
            stp.wrapSet = 1'b1;
          end else begin
            stp.inc = 1'b1;
          end
        end
        MODE_FREE: begin
          stp.step    = 1'b1;
          stp.inc     = 1'b1;
          stp.wrapSet = (count == ALL_ONES);
        end
        MODE_BOUNCE: begin
          if (cmpQ[0] != '0) begin
            stp.step = 1'b1;
            if (dirUpQ && (count < cmpQ[0])) begin
              stp.inc = 1'b1;
            end else begin
              stp.dec = 1'b1;
              if (count == ONE) begin
                stp.wrapSet = 1'b1;
                dirNext     = 1'b1;
              end else begin
                dirNext = 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R4: halt mode leaves the count alone
  assert_halt_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_HALT && !clearReq) |=> $stable(count));

  // R3: with neither tick high nothing moves
  assert_no_tick_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clearReq && !auxTick && !subTick) |=> $stable(count));

  // R7: at most one kind of move per cycle
  assert_one_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stp.inc, stp.dec, stp.zero}));

  // R7: falling phase never rests on zero
  assert_bounce_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_BOUNCE && !dirUpQ) |-> (count != '0));

  // R10: zeroing strobe empties the count
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clearReq |=> (count == '0));

endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] nextCount,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             clrReq,
  output logic             flag
);

  logic hit;

  assign hit = step && (nextCount == cmpVal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
    end else if (clrReq) begin
      flag <= 1'b0;
    end
  end

  // R8: a flag only rises after a tick-driven move
  assert_rise_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(step));

  // R9: a set flag survives any cycle without a clear request
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clrReq) |=> flag);

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  stepT                          stp,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cmpVals,
  input  logic [NUM_CH:0]               flagClr,
  output logic [CNT_W-1:0]              count,
  output logic [NUM_CH-1:0]             cmpFlag,
  output logic                          wrapFlag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] nextCount;

  always_comb begin
    nextCount = count;
    if (stp.zero) begin
      nextCount = '0;
    end else if (stp.inc) begin
      nextCount = count + ONE;
    end else if (stp.dec) begin
      nextCount = count - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      wrapFlag <= 1'b0;
    end else begin
      count <= nextCount;
      if (stp.wrapSet) begin
        wrapFlag <= 1'b1;
      end else if (flagClr[NUM_CH]) begin
        wrapFlag <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tick_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (stp.step),
      .nextCount (nextCount),
      .cmpVal    (cmpVals[i]),
      .clrReq    (flagClr[i]),
      .flag      (cmpFlag[i])
    );
  end

  // R6: an increment advances by exactly one, wrapping at the top
  assert_inc_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stp.inc |=> (count == CNT_W'($past(count) + ONE)));

  // R5: a wrap event lands on zero with the flag raised
  assert_wrap_lands_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stp.wrapSet |=> (count == '0 && wrapFlag));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auxTick,
  input  logic              subTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  count,
  output logic [NUM_CH-1:0] cmpFlag,
  output logic              wrapFlag
);

  stepT                         stp;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpVals;
  logic [NUM_CH:0]              flagClr;

  tick_timer_ctrl #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .auxTick (auxTick),
    .subTick (subTick),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .count   (count),
    .cmpVals (cmpVals),
    .flagClr (flagClr),
    .stp     (stp)
  );

  tick_timer_dp #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stp      (stp),
    .cmpVals  (cmpVals),
    .flagClr  (flagClr),
    .count    (count),
    .cmpFlag  (cmpFlag),
    .wrapFlag (wrapFlag)
  );

endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        auxTick = 1'b0;
  logic        subTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic [2:0]  cmpFlag;
  logic        wrapFlag;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // reference state
  logic [1:0]  mMode = 2'd0;
  logic        mSel = 1'b0;
  logic [15:0] mCmp [3];
  logic [15:0] mCnt = '0;
  logic        mUp = 1'b1;
  logic [2:0]  mFlag = '0;
  logic        mOvf = 1'b0;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .auxTick(auxTick), .subTick(subTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .cmpFlag(cmpFlag), .wrapFlag(wrapFlag)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelUpdate(input logic a, input logic s, input logic we,
                             input logic [2:0] ad, input logic [15:0] d);
    logic        tk;
    logic        clr;
    logic        stepF;
    logic        wr;
    logic        up;
    logic [15:0] nxt;
    tk = mSel ? s : a;
    clr = we && ad == 3'd0 && d[3];
    stepF = 1'b0;
    wr = 1'b0;
    nxt = mCnt;
    up = (mMode == 2'd3) ? mUp : 1'b1;
    if (clr) begin
      nxt = '0;
      up = 1'b1;
    end else if (tk) begin
      case (mMode)
        2'd1: begin
          stepF = 1'b1;
          if (mCnt >= mCmp[0]) begin nxt = '0; wr = 1'b1; end
          else nxt = mCnt + 16'd1;
        end
        2'd2: begin
          stepF = 1'b1;
          nxt = mCnt + 16'd1;
          wr = (mCnt == 16'hFFFF);
        end
        2'd3: begin
          if (mCmp[0] != 16'd0) begin
            stepF = 1'b1;
            if (mUp && mCnt < mCmp[0]) nxt = mCnt + 16'd1;
            else begin
              nxt = mCnt - 16'd1;
              if (mCnt == 16'd1) begin wr = 1'b1; up = 1'b1; end
              else up = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
    for (int i = 0; i < 3; i++) begin
      if (stepF && nxt == mCmp[i]) mFlag[i] = 1'b1;
      else if (we && ad == 3'd4 && d[i]) mFlag[i] = 1'b0;
    end
    if (wr) mOvf = 1'b1;
    else if (we && ad == 3'd4 && d[3]) mOvf = 1'b0;
    if (we && ad == 3'd0) begin mMode = d[1:0]; mSel = d[2]; end
    if (we && ad >= 3'd1 && ad <= 3'd3) mCmp[ad - 3'd1] = d;
    mCnt = nxt;
    mUp = up;
  endtask

  task automatic step(input logic a, input logic s, input logic we,
                      input logic [2:0] ad, input logic [15:0] d);
    @(negedge clk);
    auxTick = a; subTick = s; wrEn = we; wrAddr = ad; wrData = d;
    modelUpdate(a, s, we, ad, d);
    @(posedge clk);
    #1;
    chk(curReq, {12'd0, cmpFlag, wrapFlag, count}, {12'd0, mFlag, mOvf, mCnt});
  endtask

  task automatic wr(input logic [2:0] ad, input logic [15:0] d);
    step(1'b0, 1'b0, 1'b1, ad, d);
  endtask

  task automatic ticks(input int n, input logic a, input logic s);
    for (int k = 0; k < n; k++) step(a, s, 1'b0, 3'd0, 16'd0);
  endtask

  initial begin
    logic [15:0] base;
    logic [15:0] nextCmp;
    logic [2:0]  savedFlags;
    logic        savedOvf;
    int          hitCount;
    int          lastHit;
    int          expTri;
    for (int i = 0; i < 3; i++) mCmp[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", {12'd0, cmpFlag, wrapFlag, count}, 32'd0);
    curReq = "R1";
    ticks(3, 1'b1, 1'b1);
    chk("R1", {16'd0, count}, 32'd0);

    // R2: control word address decode
    curReq = "R2";
    wr(3'd1, 16'h8000);
    wr(3'd2, 16'd100);
    wr(3'd3, 16'hFFFF);
    wr(3'd0, 16'h0002);
    ticks(4, 1'b1, 1'b0);
    chk("R2", {16'd0, count}, 32'd4);

    // R6: full free-run sweep
    curReq = "R6";
    ticks(65537, 1'b1, 1'b0);
    chk("R6", {16'd0, count}, 32'd5);
    chk("R6", {31'd0, wrapFlag}, 32'd1);
    chk("R8", {29'd0, cmpFlag}, 32'd7);
    curReq = "R9";
    wr(3'd4, 16'h000F);
    chk("R9", {28'd0, cmpFlag, wrapFlag}, 32'd0);

    // R3: tick selection
    curReq = "R3";
    base = count;
    ticks(10, 1'b0, 1'b1);
    chk("R3", {16'd0, count}, {16'd0, base});
    wr(3'd0, 16'h0006);
    ticks(10, 1'b1, 1'b0);
    chk("R3", {16'd0, count}, {16'd0, base});
    ticks(7, 1'b0, 1'b1);
    chk("R3", {16'd0, count}, {16'd0, base + 16'd7});
    for (int k = 0; k < 12; k++) step(k[0], ~k[0], 1'b0, 3'd0, 16'd0);

    // R4: halt
    curReq = "R4";
    wr(3'd0, 16'h0004);
    base = count;
    ticks(20, 1'b1, 1'b1);
    chk("R4", {16'd0, count}, {16'd0, base});

    // R5: ramp with limit 4 (period 5)
    curReq = "R5";
    wr(3'd4, 16'h000F);
    wr(3'd1, 16'd4);
    wr(3'd0, 16'h000D);
    for (int k = 1; k <= 23; k++) begin
      step(1'b0, 1'b1, 1'b0, 3'd0, 16'd0);
      chk("R5", {16'd0, count}, k % 5);
    end
    ticks(1, 1'b0, 1'b1);
    chk("R5", {16'd0, count}, 32'd4);
    curReq = "R11";
    wr(3'd1, 16'd2);
    ticks(1, 1'b0, 1'b1);
    chk("R11", {16'd0, count}, 32'd0);
    chk("R5", {31'd0, wrapFlag}, 32'd1);

    // R7: bounce with limit 3 (period 6)
    curReq = "R7";
    wr(3'd4, 16'h000F);
    wr(3'd1, 16'd3);
    wr(3'd0, 16'h000F);
    for (int k = 1; k <= 30; k++) begin
      step(1'b0, 1'b1, 1'b0, 3'd0, 16'd0);
      expTri = (k % 6 <= 3) ? (k % 6) : (6 - k % 6);
      chk("R7", {16'd0, count}, expTri);
    end
    chk("R7", {31'd0, wrapFlag}, 32'd1);
    ticks(2, 1'b0, 1'b1);
    wr(3'd1, 16'd0);
    base = count;
    ticks(5, 1'b0, 1'b1);
    chk("R7", {16'd0, count}, {16'd0, base});

    // R10: zeroing strobe mid-fall
    curReq = "R10";
    wr(3'd1, 16'd5);
    wr(3'd0, 16'h000F);
    ticks(7, 1'b0, 1'b1);
    chk("R10", {16'd0, count}, 32'd3);
    savedFlags = cmpFlag;
    savedOvf = wrapFlag;
    step(1'b0, 1'b1, 1'b1, 3'd0, 16'h000F);
    chk("R10", {16'd0, count}, 32'd0);
    chk("R10", {28'd0, cmpFlag, wrapFlag}, {28'd0, savedFlags, savedOvf});
    ticks(2, 1'b0, 1'b1);
    chk("R10", {16'd0, count}, 32'd2);
    wr(3'd0, 16'h000C);
    ticks(3, 1'b0, 1'b1);
    chk("R10", {16'd0, count}, 32'd0);

    // R8: resting on a compare value sets nothing
    curReq = "R8";
    wr(3'd4, 16'h000F);
    wr(3'd3, 16'd0);
    ticks(4, 1'b1, 1'b1);
    chk("R8", {29'd0, cmpFlag}, 32'd0);

    // R11: offset stepping in free-run
    curReq = "R11";
    nextCmp = 16'd10;
    wr(3'd2, nextCmp);
    wr(3'd0, 16'h000E);
    hitCount = 0;
    lastHit = 0;
    for (int k = 1; k <= 80; k++) begin
      step(1'b0, 1'b1, 1'b0, 3'd0, 16'd0);
      if (cmpFlag[1]) begin
        chk("R11", k - lastHit, 32'd10);
        lastHit = k;
        hitCount++;
        nextCmp = nextCmp + 16'd10;
        wr(3'd2, nextCmp);
        wr(3'd4, 16'h0002);
      end
    end
    chk("R11", hitCount, 32'd8);

    // R9: match beats a same-cycle clear; zero bits leave flags
    curReq = "R9";
    wr(3'd4, 16'h000F);
    wr(3'd3, count + 16'd1);
    step(1'b0, 1'b1, 1'b1, 3'd4, 16'h0004);
    chk("R9", {31'd0, cmpFlag[2]}, 32'd1);
    wr(3'd4, 16'h0000);
    chk("R9", {31'd0, cmpFlag[2]}, 32'd1);
    wr(3'd4, 16'h0004);
    chk("R9", {31'd0, cmpFlag[2]}, 32'd0);

    summary();
    $finish;
  end

endmodule